// File: doc/BRIEF.md
# Zoned External Bus Controller

This block connects a simple internal request port to an asynchronous external memory bus. The top three address bits select one of eight zones. A zone can have its own chip select. Each zone has two programmable strobe waveforms, one for reads and one for writes. Each waveform has three parts: a setup part (lead), a part where the strobe is low (active), and a hold-off part (trail). Every part is counted in clock cycles.

An external master can take the bus with an active-low hold request. The controller lets the current access finish first. It then grants the bus with an active-low acknowledge and turns off every output enable it drives.

A mode input is sampled while reset is held. It decides whether zone 7 goes to the external bus. Software can later rewrite the latched bit.

Top module: `zbus_ctrl`

## Requirements
- R1: After reset the following hold: rd_n, we_n, rnw and all three chip selects are high, holda_n is high, req_ready is high, and xaddr_oe and xstrb_oe are high. Every timing field resets to 7.
- R2: An access to zone z uses one timing word. `cfg_wdata` writes it through `cfg_zone`, in this layout:
  - bits [2:0] read lead, [5:3] read active, [8:6] read trail
  - bits [11:9] write lead, [14:12] write active, [17:15] write trail

  Counting from the edge that accepts the request, the access holds its chip select and address for lead+active+trail cycles. The strobe for its direction is low only in the active cycles, which sit between lead and trail.
- R3: rd_n and we_n are never low together. rnw is low for the whole of a write access and high otherwise.
- R4: Zones 0 and 1 drive cs01_n low, zone 2 drives cs2_n low, and zones 6 and 7 drive cs67_n low. Zones 3 to 5 assert no chip select. At most one chip select is low at a time. xaddr carries the low AW-3 request address bits.
- R5: Read data on xdin is captured on the last active cycle. rsp_done pulses for one cycle, with rsp_err low, in the cycle after trail ends.
- R6: For a write, xdata_oe is high and xdout equals the request data from lead through trail. For a read, xdata_oe stays low.
- R7: A timing field of 0 behaves as 1 cycle.
- R8: A low hold_n is granted only while idle with no request present. An access that is already running completes first. While granted, holda_n is low and xaddr_oe, xdata_oe and xstrb_oe are low. holda_n returns high one cycle after hold_n rises.
- R9: While the hold is granted, req_ready stays low, so a request waits.
- R10: mode_pin is latched at reset. When the latched bit is low, zone 7 is disabled. Changes on mode_pin after reset have no effect.
- R11: A pulse on cfg_mode_we overwrites the latched zone-7 enable with cfg_mode_val.
- R12: An access to a disabled zone produces rsp_done and rsp_err in the next cycle, with rsp_rdata zero. It drives no strobe and no chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pin | input | 1 | Zone-7 enable, sampled during reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_zone | input | 3 | Zone whose timing word is written |
| cfg_wdata | input | 18 | Timing word |
| cfg_mode_we | input | 1 | Overwrite zone-7 enable |
| cfg_mode_val | input | 1 | New zone-7 enable value |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Zone in top 3 bits, offset below |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rsp_done | output | 1 | Access complete pulse |
| rsp_err | output | 1 | Access targeted a disabled zone |
| rsp_rdata | output | DW | Read data |
| xaddr | output | AW-3 | External address |
| xdout | output | DW | External write data |
| xdin | input | DW | External read data |
| xaddr_oe | output | 1 | Address output enable |
| xdata_oe | output | 1 | Data output enable |
| xstrb_oe | output | 1 | Strobe and chip-select output enable |
| cs01_n | output | 1 | Chip select, zones 0 and 1 |
| cs2_n | output | 1 | Chip select, zone 2 |
| cs67_n | output | 1 | Chip select, zones 6 and 7 |
| rd_n | output | 1 | Read strobe |
| we_n | output | 1 | Write strobe |
| rnw | output | 1 | Read-not-write |
| hold_n | input | 1 | External hold request |
| holda_n | output | 1 | Hold acknowledge |

## Verification
Take the accepting edge as 0, with lead, active and trail written L, A and T. Bus outputs are due in cycles 1 to L+A+T after that edge. rsp_done is due in cycle L+A+T+1, and the captured data is the xdin value present in cycle L+A.

The bench drives xdin with a different value in every cycle, so a capture one cycle early or late returns the wrong word. It samples each cycle on the falling edge and tracks the cycle number to check these positions.

A disabled-zone response is due in cycle 1. A hold grant or release shows one cycle after the edge that sees the request change. The bench checks each of these on the first falling edge after that edge.

// File: rtl/zbus_ctrl.sv
module zbus_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_pin,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_zone,
  input  logic [17:0]   cfg_wdata,
  input  logic          cfg_mode_we,
  input  logic          cfg_mode_val,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-4:0] xaddr,
  output logic [DW-1:0] xdout,
  input  logic [DW-1:0] xdin,
  output logic          xaddr_oe,
  output logic          xdata_oe,
  output logic          xstrb_oe,
  output logic          cs01_n,
  output logic          cs2_n,
  output logic          cs67_n,
  output logic          rd_n,
  output logic          we_n,
  output logic          rnw,
  input  logic          hold_n,
  output logic          holda_n
);
  localparam int ZW = 3;
  localparam int NZ = 1 << ZW;
  localparam int XW = AW - ZW;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_ACT, S_TRAIL, S_HOLD} st_t;

  st_t           state;
  logic [2:0]    cnt;
  logic [17:0]   tcfg [NZ];
  logic          z7_en;
  logic [8:0]    t_q;
  logic [ZW-1:0] zone_q;
  logic          wr_q;
  logic [XW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  function automatic logic [2:0] span(input logic [2:0] v);
    return (v == 3'd0) ? 3'd1 : v;
  endfunction

  logic [ZW-1:0] req_zone;
  logic [8:0]    req_t;
  logic          busy, strobe_on;

  assign req_zone  = req_addr[AW-1 -: ZW];
  assign req_t     = req_write ? tcfg[req_zone][17:9] : tcfg[req_zone][8:0];
  assign busy      = (state == S_LEAD) || (state == S_ACT) || (state == S_TRAIL);
  assign strobe_on = (state == S_ACT);

  assign req_ready = (state == S_IDLE);
  assign holda_n   = (state != S_HOLD);
  assign xaddr_oe  = holda_n;
  assign xstrb_oe  = holda_n;
  assign xdata_oe  = busy && wr_q;
  assign xaddr     = addr_q;
  assign xdout     = wdata_q;
  assign rd_n      = !(strobe_on && !wr_q);
  assign we_n      = !(strobe_on && wr_q);
  assign rnw       = !(busy && wr_q);
  assign cs01_n    = !(busy && zone_q[2:1] == 2'b00);
  assign cs2_n     = !(busy && zone_q == 3'd2);
  assign cs67_n    = !(busy && zone_q[2:1] == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      z7_en     <= mode_pin;
      t_q       <= '0;
      zone_q    <= '0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      for (int i = 0; i < NZ; i++) tcfg[i] <= '1;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      if (cfg_we)      tcfg[cfg_zone] <= cfg_wdata;
      if (cfg_mode_we) z7_en <= cfg_mode_val;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (req_zone == 3'd7 && !z7_en) begin
              rsp_done  <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
            end else begin
              zone_q  <= req_zone;
              wr_q    <= req_write;
              addr_q  <= req_addr[XW-1:0];
              wdata_q <= req_wdata;
              t_q     <= req_t;
              cnt     <= span(req_t[2:0]) - 3'd1;
              state   <= S_LEAD;
            end
          end else if (!hold_n) begin
            state <= S_HOLD;
          end
        end
        S_LEAD: begin
          if (cnt == 3'd0) begin
            state <= S_ACT;
            cnt   <= span(t_q[5:3]) - 3'd1;
          end else cnt <= cnt - 3'd1;
        end
        S_ACT: begin
          if (cnt == 3'd0) begin
            state <= S_TRAIL;
            cnt   <= span(t_q[8:6]) - 3'd1;
            if (!wr_q) rsp_rdata <= xdin;
          end else cnt <= cnt - 3'd1;
        end
        S_TRAIL: begin
          if (cnt == 3'd0) begin
            state    <= S_IDLE;
            rsp_done <= 1'b1;
          end else cnt <= cnt - 3'd1;
        end
        S_HOLD: if (hold_n) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module zbus_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_n,
  input logic          we_n,
  input logic          rnw,
  input logic          cs01_n,
  input logic          cs2_n,
  input logic          cs67_n,
  input logic          holda_n,
  input logic          xaddr_oe,
  input logic          xdata_oe,
  input logic          xstrb_oe,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          rsp_err,
  input logic [DW-1:0] rsp_rdata
);
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !we_n));
  p_rnw_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !rnw);
  p_rnw_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> rnw);
  p_cs_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!cs01_n, !cs2_n, !cs67_n}) <= 1);
  p_wdata_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xdata_oe |-> !rnw);
  p_hold_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !holda_n |-> (!xaddr_oe && !xstrb_oe && !xdata_oe));
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !holda_n |-> !req_ready);
  p_err_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> (rsp_rdata == '0 && rd_n && we_n));
endmodule

bind zbus_ctrl zbus_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .we_n(we_n), .rnw(rnw),
  .cs01_n(cs01_n), .cs2_n(cs2_n), .cs67_n(cs67_n), .holda_n(holda_n),
  .xaddr_oe(xaddr_oe), .xdata_oe(xdata_oe), .xstrb_oe(xstrb_oe),
  .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata)
);

// File: tb/sim_zbus_ctrl.sv
`timescale 1ns/1ps
module sim_zbus_ctrl;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_pin = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_zone = '0;
  logic [17:0] cfg_wdata = '0;
  logic cfg_mode_we = 1'b0, cfg_mode_val = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_done, rsp_err;
  logic [DW-1:0] rsp_rdata, xdout;
  logic [DW-1:0] xdin = '0;
  logic [AW-4:0] xaddr;
  logic xaddr_oe, xdata_oe, xstrb_oe, cs01_n, cs2_n, cs67_n, rd_n, we_n, rnw, holda_n;
  logic hold_n = 1'b1;

  always #2.5 clk = ~clk;

  zbus_ctrl #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin),
    .cfg_we(cfg_we), .cfg_zone(cfg_zone), .cfg_wdata(cfg_wdata),
    .cfg_mode_we(cfg_mode_we), .cfg_mode_val(cfg_mode_val),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .xaddr(xaddr), .xdout(xdout),
    .xdin(xdin), .xaddr_oe(xaddr_oe), .xdata_oe(xdata_oe), .xstrb_oe(xstrb_oe),
    .cs01_n(cs01_n), .cs2_n(cs2_n), .cs67_n(cs67_n), .rd_n(rd_n), .we_n(we_n),
    .rnw(rnw), .hold_n(hold_n), .holda_n(holda_n)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int bl [8][2];
  int ba [8][2];
  int bt [8][2];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [2:0] exp_cs(input int z);
    if (z < 2) return 3'b110;
    if (z == 2) return 3'b101;
    if (z >= 6) return 3'b011;
    return 3'b111;
  endfunction

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 1'b0;
    mode_pin = mode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int z = 0; z < 8; z++)
      for (int w = 0; w < 2; w++) begin
        bl[z][w] = 7; ba[z][w] = 7; bt[z][w] = 7;
      end
  endtask

  task automatic program_zone(input int z);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_zone = 3'(z);
    cfg_wdata = {3'(bt[z][1]), 3'(ba[z][1]), 3'(bl[z][1]),
                 3'(bt[z][0]), 3'(ba[z][0]), 3'(bl[z][0])};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input bit w, input int z, input bit exp_err, input int base,
                        input bit hold_during, input string tg);
    logic [DW-1:0] wd;
    logic [AW-4:0] off;
    int L, A, T, tot;
    wd  = 16'(32'hA000 + z * 16 + int'(w));
    off = 13'(z * 37 + 5 + base);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = {3'(z), off};
    req_wdata = wd;
    if (hold_during) hold_n = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_err) begin
      check(rsp_done && rsp_err, {tg, " R12 error response"}, {rsp_done, rsp_err}, 3);
      check(rsp_rdata == '0, {tg, " R12 zero data"}, rsp_rdata, 0);
      check({cs67_n, cs2_n, cs01_n, rd_n, we_n} == 5'h1f, {tg, " R12 no bus activity"},
            {cs67_n, cs2_n, cs01_n, rd_n, we_n}, 5'h1f);
      return;
    end
    L = eff(bl[z][w]); A = eff(ba[z][w]); T = eff(bt[z][w]);
    tot = L + A + T;
    for (int n = 1; n <= tot; n++) begin
      bit act;
      act = (n > L) && (n <= L + A);
      check({cs67_n, cs2_n, cs01_n} == exp_cs(z), {tg, " R4 chip select"},
            {cs67_n, cs2_n, cs01_n}, exp_cs(z));
      check(xaddr == off, {tg, " R4 address"}, xaddr, off);
      check(rd_n == !(act && !w), {tg, " R2 read strobe phase"}, rd_n, !(act && !w));
      check(we_n == !(act && w), {tg, " R2 write strobe phase"}, we_n, !(act && w));
      check(rnw == !w, {tg, " R3 rnw level"}, rnw, !w);
      check(xdata_oe == w && (!w || xdout == wd), {tg, " R6 write data"}, xdata_oe, w);
      check(!rsp_done, {tg, " R5 early done"}, rsp_done, 0);
      if (hold_during) check(holda_n, {tg, " R8 no grant mid access"}, holda_n, 1);
      xdin = 16'(base + n);
      @(negedge clk);
    end
    check(rsp_done && !rsp_err, {tg, " R5 done pulse"}, {rsp_done, rsp_err}, 2);
    if (!w) check(rsp_rdata == 16'(base + L + A), {tg, " R5 capture cycle"},
                  rsp_rdata, 16'(base + L + A));
    check({cs67_n, cs2_n, cs01_n, rd_n, we_n, rnw} == 6'h3f, {tg, " R3 bus idle after"},
          {cs67_n, cs2_n, cs01_n, rd_n, we_n, rnw}, 6'h3f);
  endtask

  initial begin
    do_reset(1'b1);
    @(negedge clk);
    check({cs67_n, cs2_n, cs01_n, rd_n, we_n, rnw} == 6'h3f, "R1 idle outputs",
          {cs67_n, cs2_n, cs01_n, rd_n, we_n, rnw}, 6'h3f);
    check(holda_n && req_ready && xaddr_oe && xstrb_oe && !xdata_oe, "R1 handshake and enables",
          {holda_n, req_ready, xaddr_oe, xstrb_oe, xdata_oe}, 5'b11110);
    access(1'b1, 1, 1'b0, 16'h0100, 1'b0, "R1 reset timing");
    access(1'b0, 6, 1'b0, 16'h0200, 1'b0, "R1 reset timing");

    for (int z = 0; z < 8; z++)
      for (int w = 0; w < 2; w++) begin
        bl[z][w] = (z + w) % 8;
        ba[z][w] = (z * 3 + 1 + w) % 8;
        bt[z][w] = (z * 5 + 2 + w) % 8;
      end
    for (int z = 0; z < 8; z++) program_zone(z);
    for (int z = 0; z < 8; z++)
      for (int w = 0; w < 2; w++)
        access(w[0], z, 1'b0, 16'h1000 * (z + 1) + 16'h40 * w, 1'b0, "R2 sweep");

    for (int w = 0; w < 2; w++) begin
      bl[3][w] = 0; ba[3][w] = 0; bt[3][w] = 0;
    end
    program_zone(3);
    access(1'b0, 3, 1'b0, 16'h7700, 1'b0, "R7 zero fields");
    access(1'b1, 3, 1'b0, 16'h7800, 1'b0, "R7 zero fields");

    @(negedge clk);
    hold_n = 1'b0;
    @(negedge clk);
    check(!holda_n, "R8 grant when idle", holda_n, 0);
    check(!xaddr_oe && !xstrb_oe && !xdata_oe, "R8 outputs released",
          {xaddr_oe, xstrb_oe, xdata_oe}, 0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {3'd2, 13'h55};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!req_ready && !holda_n, "R9 request stalled under hold", {req_ready, holda_n}, 0);
      check(rd_n && we_n, "R9 no strobe under hold", {rd_n, we_n}, 3);
    end
    hold_n = 1'b1;
    @(negedge clk);
    check(holda_n && req_ready, "R8 release after hold drop", {holda_n, req_ready}, 3);
    req_valid = 1'b0;
    access(1'b0, 2, 1'b0, 16'h2200, 1'b0, "R9 bus reclaimed");

    access(1'b1, 0, 1'b0, 16'h3300, 1'b1, "R8 hold during access");
    check(holda_n, "R8 no grant in done cycle", holda_n, 1);
    @(negedge clk);
    check(!holda_n, "R8 grant after access", holda_n, 0);
    hold_n = 1'b1;
    @(negedge clk);
    check(holda_n, "R8 acknowledge removed", holda_n, 1);

    access(1'b0, 7, 1'b0, 16'h4400, 1'b0, "R10 zone7 enabled by mode high");

    do_reset(1'b0);
    access(1'b0, 7, 1'b1, 16'h0, 1'b0, "R10 zone7 disabled");
    access(1'b1, 6, 1'b0, 16'h5500, 1'b0, "R10 zone6 unaffected");
    mode_pin = 1'b1;
    repeat (2) @(negedge clk);
    access(1'b1, 7, 1'b1, 16'h0, 1'b0, "R10 pin ignored after reset");
    @(negedge clk);
    cfg_mode_we = 1'b1; cfg_mode_val = 1'b1;
    @(negedge clk);
    cfg_mode_we = 1'b0;
    access(1'b0, 7, 1'b0, 16'h6600, 1'b0, "R11 software enable");
    @(negedge clk);
    cfg_mode_we = 1'b1; cfg_mode_val = 1'b0;
    @(negedge clk);
    cfg_mode_we = 1'b0;
    access(1'b0, 7, 1'b1, 16'h0, 1'b0, "R11 software disable");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule